// File: doc/BRIEF.md
# Flash Power-Mode and Command-Reset Controller

This block sits beside the array of an asynchronous parallel flash device. It works out the device's power state, and its command-interface state, from the chip-enable, output-enable, write-enable and reset/power-down pins, which are sampled on a system clock. The block decides when the data bus is driven and when a bus write counts as a command write. It runs a two-step program/erase command interpreter and models the embedded operation with an internal busy counter. It reports the power mode on a 2-bit output, and a read-source select tells the datapath whether a read returns array data, status, or invalid data.

The reset/power-down pin overrides everything else. It drops the block into deep power-down and kills any running program or erase, marking the array contents as corrupted. It also clears the completion bits of the status register and puts the command interpreter back in read-array mode. On wake-up, a recovery counter holds the device not-ready for a set number of cycles. Standby waits for any embedded operation to finish. After a read whose address has stayed stable, the block falls into an automatic power-saving state and keeps its data valid until the next access.

Top module: `flashPowerModeCtrl`

## Requirements
- R1: Mode encoding is 00 active, 01 auto power-save, 10 standby, 11 deep power-down. When reset/power-down (`rpN`) is sampled low, mode is 11 after that clock edge, whatever the other pins are. After the block reset, mode is 11.
- R2: With `rpN` high, `ceN` low and no completed read, mode is 00.
- R3: Hold `ceN` and `oeN` low, `weN` high, the device ready and the address unchanged for ACC_CYC+1 rising edges, counted from the edge that first samples the address. Mode is then 01, and not before. Mode stays 01 when `oeN` rises. The edge that samples a different address, or a low `weN`, returns mode to 00.
- R4: With `rpN` high, `ceN` high and no operation busy, mode becomes 10 after one edge. If the command interpreter is waiting for the second write of a sequence, mode is 00 instead.
- R5: While `busy` is high, mode is 00 even with `ceN` high. Standby appears one edge after `busy` falls.
- R6: `dqDriveEn` is high exactly when `rpN` is high, `ceN` is low, `oeN` is low and `weN` is high. It is a combinational function of those pins.
- R7: A command write is accepted at the first edge on which `ceN` and `weN` are both low, provided `rpN` is high and the device is ready. `wrStrobe` is then high for the one cycle after that edge. With either pin high, no write is accepted.
- R8: Command codes: 0x40 followed by any data byte starts a program. 0x20 followed by 0xD0 starts an erase. 0x20 followed by any other byte returns to read-array without starting. 0x70 selects status reads and 0xFF selects array reads. `busy` rises after the edge that accepts the second write.
- R9: `statusOut` bit 7 is the inverse of `busy`. Bit 4 is set when a program completes and bit 5 is set when an erase completes. All other bits read 0.
- R10: When `rpN` is sampled low while busy, `busy` is low and `arrayBad` is high after that edge. `arrayBad` clears when the next program or erase starts.
- R11: When `rpN` is sampled low, status bits 5 and 4 are clear after that edge. The command interpreter returns to read-array mode.
- R12: `notReady` is high while `rpN` is low and for REC_CYC edges after `rpN` is first sampled high. While it is high, `readSel` is 10 (invalid data) and bus writes are ignored.
- R13: `readSel` is 00 in read-array mode and 01 in status mode or a setup state. Commands written while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Block reset, active low (power-up) |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| rpN | input | 1 | Reset / deep power-down, active low |
| addr | input | ADDR_W | Read address |
| cmdData | input | 8 | Data byte of a bus write |
| mode | output | 2 | Power mode (R1 encoding) |
| dqDriveEn | output | 1 | Data bus driven (1) or high impedance (0) |
| wrStrobe | output | 1 | One-cycle pulse per accepted command write |
| notReady | output | 1 | Wake-up recovery in progress |
| busy | output | 1 | Program or erase in progress |
| arrayBad | output | 1 | Last operation aborted, array contents invalid |
| readSel | output | 2 | Read source: 00 array, 01 status, 10 invalid |
| statusOut | output | 8 | Status register |

## Verification
If the command state is wrong, `readSel` shows it on the very next read. It also shows up as standby being held off with `ceN` high, and as `busy` failing to rise on a second write. A wrong access counter moves the edge at which mode reaches 01 by one cycle. For that reason the bench samples the exact edge, once per address in a full address sweep. A stale busy or recovery counter shows in the standby edge, in the status bits, or in `notReady` lasting one cycle too long or too short. All of these are visible within a few cycles of the stimulus.

// File: rtl/flashPwrPkg.sv
`timescale 1ns/1ps
package flashPwrPkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'b00,
    MODE_APS     = 2'b01,
    MODE_STANDBY = 2'b10,
    MODE_DPD     = 2'b11
  } pwrMode_e;

  typedef enum logic [1:0] {
    CMD_READ_ARRAY,
    CMD_READ_STATUS,
    CMD_PROG_SETUP,
    CMD_ERASE_SETUP
  } cmdState_e;

  localparam logic [1:0] SEL_ARRAY   = 2'b00;
  localparam logic [1:0] SEL_STATUS  = 2'b01;
  localparam logic [1:0] SEL_INVALID = 2'b10;

  localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_ERASE_CONF  = 8'hD0;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;

  // control -> datapath
  typedef struct packed {
    logic startProg;
    logic startErase;
    logic abortOp;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic addrStable;
    logic accessDone;
    logic notReady;
    logic wrAccept;
    logic opLast;
  } dpFlags_t;

endpackage

// File: rtl/flashPwrDatapath.sv
`timescale 1ns/1ps
module flashPwrDatapath
  import flashPwrPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ACC_CYC   = 4,
  parameter int REC_CYC   = 6,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              rpN,
  input  logic [ADDR_W-1:0] addr,
  input  dpStrobe_t         strobe,
  output dpFlags_t          flags
);

  localparam int ACC_W  = $clog2(ACC_CYC + 1);
  localparam int REC_W  = $clog2(REC_CYC + 1);
  localparam int OP_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int OP_W   = $clog2(OP_MAX + 1);

  localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(ACC_CYC - 1);
  localparam logic [ACC_W-1:0] ACC_TOP  = ACC_W'(ACC_CYC);
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CYC);
  localparam logic [OP_W-1:0]  PROG_LD  = OP_W'(PROG_CYC);
  localparam logic [OP_W-1:0]  ERASE_LD = OP_W'(ERASE_CYC);

  logic [ADDR_W-1:0] prevAddr;
  logic [ACC_W-1:0]  accCnt;
  logic [REC_W-1:0]  recCnt;
  logic [OP_W-1:0]   opCnt;
  logic              wrPrev;

  logic addrStable;
  logic readCond;
  logic wrAct;
  logic notReady;

  assign addrStable = (addr == prevAddr);
  assign notReady   = (recCnt != '0);
  assign readCond   = rpN & ~ceN & ~oeN & weN & ~notReady;
  assign wrAct      = rpN & ~ceN & ~weN;

  // address history and read-access timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= '0;
      accCnt   <= '0;
    end else begin
      prevAddr <= addr;
      if (readCond && addrStable) begin
        if (accCnt != ACC_TOP) accCnt <= accCnt + 1'b1;
      end else begin
        accCnt <= '0;
      end
    end
  end

  // wake-up recovery timer: held loaded while powered down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= REC_LOAD;
    end else if (!rpN) begin
      recCnt <= REC_LOAD;
    end else if (recCnt != '0) begin
      recCnt <= recCnt - 1'b1;
    end
  end

  // embedded operation timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCnt <= '0;
    end else if (strobe.abortOp) begin
      opCnt <= '0;
    end else if (strobe.startProg) begin
      opCnt <= PROG_LD;
    end else if (strobe.startErase) begin
      opCnt <= ERASE_LD;
    end else if (opCnt != '0) begin
      opCnt <= opCnt - 1'b1;
    end
  end

  // write-cycle edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrAct;
  end

  always_comb begin
    flags.addrStable = addrStable;
    flags.accessDone = readCond & addrStable & (accCnt >= ACC_LAST);
    flags.notReady   = notReady;
    flags.wrAccept   = wrAct & ~wrPrev & ~notReady;
    flags.opLast     = (opCnt == OP_W'(1));
  end

endmodule

// File: rtl/flashPwrCtrl.sv
`timescale 1ns/1ps
module flashPwrCtrl
  import flashPwrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       rpN,
  input  logic [7:0] cmdData,
  input  dpFlags_t   flags,
  output dpStrobe_t  strobe,
  output pwrMode_e   mode,
  output cmdState_e  cmdState,
  output logic       busy,
  output logic       arrayBad,
  output logic       progDone,
  output logic       eraseDone,
  output logic       wrStrobe
);

  cmdState_e cmdNext;
  pwrMode_e  modeNext;
  logic      inSetup;

  assign inSetup = (cmdState == CMD_PROG_SETUP) || (cmdState == CMD_ERASE_SETUP);

  // command interpreter
  always_comb begin
    cmdNext           = cmdState;
    strobe.startProg  = 1'b0;
    strobe.startErase = 1'b0;
    strobe.abortOp    = ~rpN;
    if (!rpN) begin
      cmdNext = CMD_READ_ARRAY;
    end else if (flags.wrAccept && !busy) begin
      unique case (cmdState)
        CMD_PROG_SETUP: begin
          strobe.startProg = 1'b1;
          cmdNext          = CMD_READ_STATUS;
        end
        CMD_ERASE_SETUP: begin
          if (cmdData == OP_ERASE_CONF) begin
            strobe.startErase = 1'b1;
            cmdNext           = CMD_READ_STATUS;
          end else begin
            cmdNext = CMD_READ_ARRAY;
          end
        end
        default: begin
          if (cmdData == OP_PROG_SETUP)       cmdNext = CMD_PROG_SETUP;
          else if (cmdData == OP_ERASE_SETUP) cmdNext = CMD_ERASE_SETUP;
          else if (cmdData == OP_READ_STATUS) cmdNext = CMD_READ_STATUS;
          else                                cmdNext = CMD_READ_ARRAY;
        end
      endcase
    end
  end

  // power-mode decision
  always_comb begin
    if (!rpN) begin
      modeNext = MODE_DPD;
    end else if (busy) begin
      modeNext = MODE_ACTIVE;
    end else if (ceN) begin
      modeNext = inSetup ? MODE_ACTIVE : MODE_STANDBY;
    end else if (mode == MODE_APS) begin
      if (!flags.addrStable || !weN || flags.notReady) modeNext = MODE_ACTIVE;
      else                                             modeNext = MODE_APS;
    end else begin
      modeNext = flags.accessDone ? MODE_APS : MODE_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_DPD;
      cmdState  <= CMD_READ_ARRAY;
      busy      <= 1'b0;
      arrayBad  <= 1'b0;
      progDone  <= 1'b0;
      eraseDone <= 1'b0;
      wrStrobe  <= 1'b0;
    end else begin
      mode     <= modeNext;
      cmdState <= cmdNext;
      wrStrobe <= flags.wrAccept;
      if (!rpN) begin
        if (busy) arrayBad <= 1'b1;
        busy      <= 1'b0;
        progDone  <= 1'b0;
        eraseDone <= 1'b0;
      end else if (strobe.startProg || strobe.startErase) begin
        busy     <= 1'b1;
        arrayBad <= 1'b0;
      end else if (busy && flags.opLast) begin
        busy <= 1'b0;
        if (cmdState == CMD_READ_STATUS || cmdState == CMD_READ_ARRAY) begin
          progDone  <= progDone  | ~eraseRun;
          eraseDone <= eraseDone |  eraseRun;
        end
      end
    end
  end

  // which kind of operation is running
  logic eraseRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  eraseRun <= 1'b0;
    else if (strobe.startErase) eraseRun <= 1'b1;
    else if (strobe.startProg)  eraseRun <= 1'b0;
  end

endmodule

// File: rtl/flashPowerModeCtrl.sv
`timescale 1ns/1ps
module flashPowerModeCtrl
  import flashPwrPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ACC_CYC   = 4,
  parameter int REC_CYC   = 6,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              rpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmdData,
  output logic [1:0]        mode,
  output logic              dqDriveEn,
  output logic              wrStrobe,
  output logic              notReady,
  output logic              busy,
  output logic              arrayBad,
  output logic [1:0]        readSel,
  output logic [7:0]        statusOut
);

  dpStrobe_t strobe;
  dpFlags_t  flags;
  pwrMode_e  modeQ;
  cmdState_e cmdState;
  logic      progDone;
  logic      eraseDone;

  flashPwrDatapath #(
    .ADDR_W   (ADDR_W),
    .ACC_CYC  (ACC_CYC),
    .REC_CYC  (REC_CYC),
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ceN   (ceN),
    .oeN   (oeN),
    .weN   (weN),
    .rpN   (rpN),
    .addr  (addr),
    .strobe(strobe),
    .flags (flags)
  );

  flashPwrCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .weN      (weN),
    .rpN      (rpN),
    .cmdData  (cmdData),
    .flags    (flags),
    .strobe   (strobe),
    .mode     (modeQ),
    .cmdState (cmdState),
    .busy     (busy),
    .arrayBad (arrayBad),
    .progDone (progDone),
    .eraseDone(eraseDone),
    .wrStrobe (wrStrobe)
  );

  assign mode      = modeQ;
  assign notReady  = flags.notReady;
  assign dqDriveEn = rpN & ~ceN & ~oeN & weN;
  assign statusOut = {~busy, 1'b0, eraseDone, progDone, 4'b0000};

  always_comb begin
    if (flags.notReady)                  readSel = SEL_INVALID;
    else if (cmdState == CMD_READ_ARRAY) readSel = SEL_ARRAY;
    else                                 readSel = SEL_STATUS;
  end

endmodule

// File: rtl/flashPwrChecker.sv
`timescale 1ns/1ps
module flashPwrChecker (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       weN,
  input logic       rpN,
  input logic [1:0] mode,
  input logic       busy,
  input logic       arrayBad,
  input logic       wrStrobe,
  input logic       notReady,
  input logic [7:0] statusOut
);

  p_dpd_override_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> (mode == 2'b11));

  p_busy_keeps_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rpN) |=> (mode == 2'b00));

  p_write_inhibit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || weN) |=> !wrStrobe);

  p_abort_marks_bad_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rpN) |=> (!busy && arrayBad));

  p_status_cleared_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> (statusOut[5:4] == 2'b00));

  p_wake_not_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> notReady);

  p_ready_bit_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> statusOut[7]);

endmodule

bind flashPowerModeCtrl flashPwrChecker i_flashPwrChecker (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .weN      (weN),
  .rpN      (rpN),
  .mode     (mode),
  .busy     (busy),
  .arrayBad (arrayBad),
  .wrStrobe (wrStrobe),
  .notReady (notReady),
  .statusOut(statusOut)
);

// File: tb/test_flashPowerModeCtrl.sv
`timescale 1ns/1ps
module test_flashPowerModeCtrl;

  localparam int ADDR_W    = 4;
  localparam int ACC_CYC   = 3;
  localparam int REC_CYC   = 4;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              ceN, oeN, weN, rpN;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        cmdData;
  logic [1:0]        mode;
  logic              dqDriveEn, wrStrobe, notReady, busy, arrayBad;
  logic [1:0]        readSel;
  logic [7:0]        statusOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flashPowerModeCtrl #(
    .ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .REC_CYC(REC_CYC),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_flashPowerModeCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .rpN(rpN),
    .addr(addr), .cmdData(cmdData), .mode(mode), .dqDriveEn(dqDriveEn),
    .wrStrobe(wrStrobe), .notReady(notReady), .busy(busy), .arrayBad(arrayBad),
    .readSel(readSel), .statusOut(statusOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wrCmd(input logic [7:0] d, output logic strobeSeen);
    cmdData = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick();
    strobeSeen = wrStrobe;
    weN = 1'b1;
    tick();
  endtask

  task automatic doReset();
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; rpN = 1'b1;
    addr = '0; cmdData = '0;
    ticks(2);
    rstN = 1'b1;
    ticks(REC_CYC + 1);
  endtask

  task automatic waitIdle(input string req);
    int guard = 0;
    while (busy && guard < 100) begin
      if (mode != 2'b00) chk(req, {6'b0, mode}, 8'h00);
      tick();
      guard++;
    end
    chk(req, {7'b0, busy}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    logic expDq;
    logic [ADDR_W-1:0] cur;
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; rpN = 1'b1;
    addr = '0; cmdData = '0;
    @(negedge clk);
    // R1/R13 reset state
    chk("R1 reset mode", {6'b0, mode}, 8'h03);
    chk("R12 reset notReady", {7'b0, notReady}, 8'h01);
    chk("R12 reset readSel", {6'b0, readSel}, 8'h02);
    chk("R9 reset status", statusOut, 8'h80);
    chk("R13 reset busy", {7'b0, busy}, 8'h00);
    ticks(2);
    rstN = 1'b1;

    // R6 exhaustive sweep of the four control pins
    for (int i = 0; i < 16; i++) begin
      {rpN, ceN, oeN, weN} = 4'(i);
      #0.5;
      expDq = rpN & ~ceN & ~oeN & weN;
      chk("R6 dqDriveEn", {7'b0, dqDriveEn}, {7'b0, expDq});
      tick();
    end
    doReset();

    // R1 override while a read is set up
    ceN = 1'b0; oeN = 1'b0; rpN = 1'b0;
    tick();
    chk("R1 dpd mode", {6'b0, mode}, 8'h03);
    chk("R6 hi-z in dpd", {7'b0, dqDriveEn}, 8'h00);
    // R12 recovery timing and ignored writes
    rpN = 1'b1;
    wrCmd(8'h70, s);
    chk("R12 write ignored strobe", {7'b0, s}, 8'h00);
    ticks(REC_CYC - 3);
    chk("R12 still not ready", {7'b0, notReady}, 8'h01);
    chk("R12 invalid readSel", {6'b0, readSel}, 8'h02);
    tick();
    chk("R12 ready", {7'b0, notReady}, 8'h00);
    chk("R12 write ignored readSel", {6'b0, readSel}, 8'h00);

    // R4 standby
    ceN = 1'b1; oeN = 1'b0;
    tick();
    chk("R4 standby", {6'b0, mode}, 8'h02);
    chk("R6 hi-z standby", {7'b0, dqDriveEn}, 8'h00);

    // R2/R3 auto power-save entry timing
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = 4'd5; cur = 4'd5;
    ticks(ACC_CYC);
    chk("R2 active before access done", {6'b0, mode}, 8'h00);
    tick();
    chk("R3 aps entered", {6'b0, mode}, 8'h01);
    oeN = 1'b1;
    tick();
    chk("R3 aps holds oe high", {6'b0, mode}, 8'h01);
    oeN = 1'b0;
    for (int a = 0; a < 16; a++) begin
      if (4'(a) != cur) begin
        addr = 4'(a); cur = 4'(a);
        tick();
        chk("R3 new address exits aps", {6'b0, mode}, 8'h00);
        ticks(ACC_CYC - 1);
        chk("R3 not yet aps", {6'b0, mode}, 8'h00);
        tick();
        chk("R3 aps again", {6'b0, mode}, 8'h01);
      end
    end
    // R3/R7 write in aps
    cmdData = 8'hFF; weN = 1'b0;
    tick();
    chk("R3 write exits aps", {6'b0, mode}, 8'h00);
    chk("R7 strobe", {7'b0, wrStrobe}, 8'h01);
    tick();
    chk("R7 held low no second strobe", {7'b0, wrStrobe}, 8'h00);
    weN = 1'b1;
    // R7 inhibit combos
    for (int i = 0; i < 3; i++) begin
      ceN = (i != 1); weN = (i != 0);
      tick();
      chk("R7 inhibited", {7'b0, wrStrobe}, 8'h00);
    end
    ceN = 1'b0; weN = 1'b1; oeN = 1'b1;
    tick();

    // R8/R4/R5/R9 program
    wrCmd(8'h40, s);
    chk("R7 accepted", {7'b0, s}, 8'h01);
    chk("R13 setup readSel", {6'b0, readSel}, 8'h01);
    ceN = 1'b1;
    tick();
    chk("R4 setup blocks standby", {6'b0, mode}, 8'h00);
    wrCmd(8'h12, s);
    chk("R8 program busy", {7'b0, busy}, 8'h01);
    ceN = 1'b1;
    waitIdle("R5 busy active");
    chk("R5 mode at busy fall", {6'b0, mode}, 8'h00);
    tick();
    chk("R5 standby after busy", {6'b0, mode}, 8'h02);
    chk("R9 program done", statusOut, 8'h90);

    // R13 read select commands
    wrCmd(8'hFF, s);
    chk("R13 read array", {6'b0, readSel}, 8'h00);
    wrCmd(8'h70, s);
    chk("R13 read status", {6'b0, readSel}, 8'h01);
    // R8 erase cancel
    wrCmd(8'h20, s);
    wrCmd(8'h55, s);
    chk("R8 cancel not busy", {7'b0, busy}, 8'h00);
    chk("R8 cancel read array", {6'b0, readSel}, 8'h00);

    // R10/R11 abort
    wrCmd(8'h20, s);
    wrCmd(8'hD0, s);
    chk("R8 erase busy", {7'b0, busy}, 8'h01);
    ticks(2);
    rpN = 1'b0;
    tick();
    chk("R10 abort busy", {7'b0, busy}, 8'h00);
    chk("R10 array bad", {7'b0, arrayBad}, 8'h01);
    chk("R11 status cleared", statusOut, 8'h80);
    chk("R1 abort dpd", {6'b0, mode}, 8'h03);
    rpN = 1'b1;
    ticks(REC_CYC);
    chk("R11 read array after", {6'b0, readSel}, 8'h00);
    chk("R10 bad held", {7'b0, arrayBad}, 8'h01);

    // R9/R10/R13 full erase with ignored write
    wrCmd(8'h20, s);
    wrCmd(8'hD0, s);
    chk("R10 bad cleared on start", {7'b0, arrayBad}, 8'h00);
    wrCmd(8'hFF, s);
    waitIdle("R13 erase run");
    tick();
    chk("R13 busy write ignored", {6'b0, readSel}, 8'h01);
    chk("R9 erase done", statusOut, 8'hA0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule